// File: doc/BRIEF.md
# LCD Frame Timing Generator

This block produces the line-rate and field-rate timing for a matrix LCD column driver. It divides the oscillator clock to form a line clock, raises a field-start flag for the first line of every field, and steps a two-bit drive-pattern pair through an eight-step cycle at a chosen line interval. It also flips an AC polarity signal after a programmed number of lines, and carries display-blank and sleep indications.

A host writes opcode bytes and their parameter bytes through a small register port, where `cmd_param` tells the two kinds apart. In master mode the block drives all timing outputs from its own counters. In slave mode it takes the same signals from a master device and passes them to its outputs one clock later. The sleep output always comes from the block's own command state.

Top module: `lcd_frame_timer`

## Requirements
- R1: After reset the block is in master-driven state with display blanked (`doff_out`=1), not asleep (`slp_out`=0), `cl_out`=0, `ca_out`=1, `fr_out`=0 and (`f2_out`,`f1_out`)=(1,1), with 240-line fields, divide-by-2, pattern interval 8 and FR line count 10.
- R2: One line lasts LINE_TICKS × ratio clock cycles, where the ratio is set by opcode 0xBF with parameter bits [1:0]: 00 gives 2, 01 gives 1, 10 gives 4, 11 gives 8.
- R3: Opcode 0xA8 with parameter bits [5:0] = p sets a field of 4·(p+1) lines, and `ca_out` is 1 for exactly the first line of each field.
- R4: The pair (`f2_out`,`f1_out`) follows the step cycle 0..7 as (1,1),(1,0),(0,1),(0,0),(0,0),(0,1),(1,0),(1,1), wrapping after step 7.
- R5: Opcode 0xCC with parameter bits [1:0] sets how often the step advances within a field: 00 every 8 lines, 01 every 4, 10 every 16, 11 never inside a field (only at field start).
- R6: Each new field starts its step one further along the cycle than the previous field started; the first field after reset starts at step 0.
- R7: Opcode 0xCA with parameter bits [3:0] = N makes `fr_out` toggle every N+1 lines, independent of field boundaries.
- R8: In master mode `ca_out`, `fr_out`, `f1_out` and `f2_out` change only on the cycle in which `cl_out` falls.
- R9: Opcode 0xAF unblanks and 0xAE blanks the display; 0x95 enters sleep and forces blanking; 0x94 leaves sleep with the display still blanked; 0xAF has no effect while asleep.
- R10: While asleep, all line-rate timing is frozen and no master timing output changes.
- R11: In slave mode `cl_out`, `ca_out`, `f1_out`, `f2_out`, `fr_out` and `doff_out` equal their matching inputs delayed by one clock, while `slp_out` still follows the sleep commands.
- R12: A parameter byte is used only when it directly follows an opcode that takes one; a parameter with no such opcode before it is ignored, and any opcode cancels a pending parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master | input | 1 | 1 = generate timing, 0 = follow external timing |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_param | input | 1 | 1 = parameter byte, 0 = opcode byte |
| cmd_byte | input | 8 | Opcode or parameter value |
| cl_in | input | 1 | External line clock (slave) |
| ca_in | input | 1 | External field start (slave) |
| f1_in | input | 1 | External pattern bit 1 (slave) |
| f2_in | input | 1 | External pattern bit 2 (slave) |
| fr_in | input | 1 | External AC polarity (slave) |
| doff_in | input | 1 | External display blank (slave) |
| cl_out | output | 1 | Line clock |
| ca_out | output | 1 | Field-start flag |
| f1_out | output | 1 | Drive pattern bit 1 |
| f2_out | output | 1 | Drive pattern bit 2 |
| fr_out | output | 1 | AC polarity |
| doff_out | output | 1 | Display blank |
| slp_out | output | 1 | Sleep indication |

## Verification
The assertions assume that `master` changes only while reset is held, so the mode-specific properties compare like with like, and that slave inputs are held at zero during reset. The bench switches mode only inside its reset task and keeps every slave input low there. Timing is reconfigured only while the block is asleep, so each field pattern is checked from a known start at line 0, step 0.

// File: rtl/lcd_ft_pkg.sv
// Shared opcodes, pending-parameter type and small decode functions
// for the LCD frame timing generator. Assumes 8-bit command bytes.
package lcd_ft_pkg;

    localparam logic [7:0] OP_DIV      = 8'hBF;
    localparam logic [7:0] OP_DUTY     = 8'hA8;
    localparam logic [7:0] OP_IVL      = 8'hCC;
    localparam logic [7:0] OP_FRN      = 8'hCA;
    localparam logic [7:0] OP_DISP_ON  = 8'hAF;
    localparam logic [7:0] OP_DISP_OFF = 8'hAE;
    localparam logic [7:0] OP_SLP_IN   = 8'h95;
    localparam logic [7:0] OP_SLP_OUT  = 8'h94;

    typedef enum logic [2:0] {
        PEND_NONE,
        PEND_DIV,
        PEND_DUTY,
        PEND_IVL,
        PEND_FRN
    } pend_t;

    // Step index to (F2,F1): first half inverts the low bits, second half copies them.
    function automatic logic [1:0] pat_of_step(input logic [2:0] s);
        return s[2] ? s[1:0] : ~s[1:0];
    endfunction

    // Divider code to clock ratio.
    function automatic logic [3:0] div_ratio(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd2;
            2'b01:   return 4'd1;
            2'b10:   return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    // Pattern interval code to line count; 0 means once per field.
    function automatic logic [4:0] ivl_lines(input logic [1:0] code);
        case (code)
            2'b00:   return 5'd8;
            2'b01:   return 5'd4;
            2'b10:   return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/lcd_ft_cmd.sv
// Command decoder: holds the timing configuration and the display and
// sleep state. Assumes one byte per cycle with cmd_valid; a parameter
// byte applies only to the opcode directly before it.
module lcd_ft_cmd
    import lcd_ft_pkg::*;
#(
    parameter int DUTY_W   = 6,
    parameter int FRN_W    = 4,
    parameter int DUTY_RST = 59,
    parameter int FRN_RST  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_param,
    input  logic [7:0]        cmd_byte,
    output logic [1:0]        div_code,
    output logic [DUTY_W-1:0] duty_p,
    output logic [1:0]        ivl_code,
    output logic [FRN_W-1:0]  fr_n,
    output logic              disp_off,
    output logic              sleep
);

    pend_t pend;

    // Decode opcodes, apply parameters and track the pending opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= PEND_NONE;
            div_code <= 2'b00;
            duty_p   <= DUTY_W'(DUTY_RST);
            ivl_code <= 2'b00;
            fr_n     <= FRN_W'(FRN_RST);
            disp_off <= 1'b1;
            sleep    <= 1'b0;
        end else if (cmd_valid) begin
            if (cmd_param) begin
                case (pend)
                    PEND_DIV:  div_code <= cmd_byte[1:0];
                    PEND_DUTY: duty_p   <= cmd_byte[DUTY_W-1:0];
                    PEND_IVL:  ivl_code <= cmd_byte[1:0];
                    PEND_FRN:  fr_n     <= cmd_byte[FRN_W-1:0];
                    default:   ;
                endcase
                pend <= PEND_NONE;
            end else begin
                pend <= PEND_NONE;
                case (cmd_byte)
                    OP_DIV:      pend <= PEND_DIV;
                    OP_DUTY:     pend <= PEND_DUTY;
                    OP_IVL:      pend <= PEND_IVL;
                    OP_FRN:      pend <= PEND_FRN;
                    OP_DISP_ON:  if (!sleep) disp_off <= 1'b0;
                    OP_DISP_OFF: disp_off <= 1'b1;
                    OP_SLP_IN:   begin sleep <= 1'b1; disp_off <= 1'b1; end
                    OP_SLP_OUT:  sleep <= 1'b0;
                    default:     ;
                endcase
            end
        end
    end

endmodule

// File: rtl/lcd_ft_clkdiv.sv
// Prescaler: emits a one-cycle tick every 1, 2, 4 or 8 clocks.
// Assumes run is low during sleep; the count then holds.
module lcd_ft_clkdiv
    import lcd_ft_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] div_code,
    output logic       tick
);

    logic [2:0] cnt;
    logic [3:0] ratio;

    assign ratio = div_ratio(div_code);
    assign tick  = run && ({1'b0, cnt} >= ratio - 4'd1);

    // Count clocks up to the ratio, restarting on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= tick ? 3'd0 : cnt + 3'd1;
    end

endmodule

// File: rtl/lcd_ft_seq.sv
// Line and field sequencer: forms the line clock from ticks, counts
// lines per field, steps the drive pattern and toggles AC polarity.
// Every line-rate update happens at the line boundary, where CL falls.
// Assumes LINE_TICKS >= 2.
module lcd_ft_seq
    import lcd_ft_pkg::*;
#(
    parameter int LINE_TICKS = 4,
    parameter int DUTY_W     = 6,
    parameter int FRN_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DUTY_W-1:0] duty_p,
    input  logic [1:0]        ivl_code,
    input  logic [FRN_W-1:0]  fr_n,
    output logic              cl,
    output logic              ca,
    output logic [1:0]        pat,
    output logic              fr
);

    localparam int POS_W  = (LINE_TICKS > 1) ? $clog2(LINE_TICKS) : 1;
    localparam int LINE_W = DUTY_W + 2;
    localparam int HALF   = LINE_TICKS / 2;

    logic [POS_W-1:0]  pos;
    logic [LINE_W-1:0] line_idx;
    logic [LINE_W-1:0] last_line;
    logic [2:0]        fstart;
    logic [2:0]        step;
    logic [3:0]        iv_cnt;
    logic [4:0]        iv_len;
    logic [FRN_W-1:0]  fr_cnt;
    logic              boundary;

    assign last_line = {duty_p, 2'b11};
    assign iv_len    = ivl_lines(ivl_code);
    assign boundary  = tick && (pos == POS_W'(LINE_TICKS - 1));

    // Tick position inside the current line.
    always_ff @(posedge clk) begin
        if (!rst_n)        pos <= '0;
        else if (boundary) pos <= '0;
        else if (tick)     pos <= pos + 1'b1;
    end

    // Line index, field start step and pattern step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_idx <= '0;
            fstart   <= 3'd0;
            step     <= 3'd0;
            iv_cnt   <= 4'd0;
        end else if (boundary) begin
            if (line_idx >= last_line) begin
                line_idx <= '0;
                fstart   <= fstart + 3'd1;
                step     <= fstart + 3'd1;
                iv_cnt   <= 4'd0;
            end else begin
                line_idx <= line_idx + 1'b1;
                if (iv_len != 5'd0) begin
                    if ({1'b0, iv_cnt} >= iv_len - 5'd1) begin
                        iv_cnt <= 4'd0;
                        step   <= step + 3'd1;
                    end else begin
                        iv_cnt <= iv_cnt + 4'd1;
                    end
                end
            end
        end
    end

    // AC polarity toggles after fr_n+1 lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_cnt <= '0;
            fr     <= 1'b0;
        end else if (boundary) begin
            if (fr_cnt >= fr_n) begin
                fr_cnt <= '0;
                fr     <= ~fr;
            end else begin
                fr_cnt <= fr_cnt + 1'b1;
            end
        end
    end

    assign cl  = (pos >= POS_W'(HALF));
    assign ca  = (line_idx == '0);
    assign pat = pat_of_step(step);

endmodule

// File: rtl/lcd_frame_timer.sv
// Top level of the LCD frame timing generator. In master mode the
// outputs come from the internal sequencer; in slave mode they are the
// external inputs re-timed by one flop. Sleep stops the prescaler.
// Assumes master changes only while reset is held.
module lcd_frame_timer
    import lcd_ft_pkg::*;
#(
    parameter int LINE_TICKS = 4,
    parameter int DUTY_W     = 6,
    parameter int FRN_W      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master,
    input  logic       cmd_valid,
    input  logic       cmd_param,
    input  logic [7:0] cmd_byte,
    input  logic       cl_in,
    input  logic       ca_in,
    input  logic       f1_in,
    input  logic       f2_in,
    input  logic       fr_in,
    input  logic       doff_in,
    output logic       cl_out,
    output logic       ca_out,
    output logic       f1_out,
    output logic       f2_out,
    output logic       fr_out,
    output logic       doff_out,
    output logic       slp_out
);

    localparam int EXT_W = 6;

    logic [1:0]        div_code;
    logic [DUTY_W-1:0] duty_p;
    logic [1:0]        ivl_code;
    logic [FRN_W-1:0]  fr_n;
    logic              disp_off;
    logic              sleep;
    logic              tick;
    logic              g_cl, g_ca, g_fr;
    logic [1:0]        g_pat;
    logic [EXT_W-1:0]  ext_q;

    lcd_ft_cmd #(
        .DUTY_W(DUTY_W),
        .FRN_W (FRN_W)
    ) i_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_param(cmd_param),
        .cmd_byte (cmd_byte),
        .div_code (div_code),
        .duty_p   (duty_p),
        .ivl_code (ivl_code),
        .fr_n     (fr_n),
        .disp_off (disp_off),
        .sleep    (sleep)
    );

    lcd_ft_clkdiv i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (~sleep),
        .div_code(div_code),
        .tick    (tick)
    );

    lcd_ft_seq #(
        .LINE_TICKS(LINE_TICKS),
        .DUTY_W    (DUTY_W),
        .FRN_W     (FRN_W)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .duty_p  (duty_p),
        .ivl_code(ivl_code),
        .fr_n    (fr_n),
        .cl      (g_cl),
        .ca      (g_ca),
        .pat     (g_pat),
        .fr      (g_fr)
    );

    // Re-time the external timing inputs for slave operation.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= '0;
        else        ext_q <= {doff_in, fr_in, f2_in, f1_in, ca_in, cl_in};
    end

    assign cl_out   = master ? g_cl     : ext_q[0];
    assign ca_out   = master ? g_ca     : ext_q[1];
    assign f1_out   = master ? g_pat[0] : ext_q[2];
    assign f2_out   = master ? g_pat[1] : ext_q[3];
    assign fr_out   = master ? g_fr     : ext_q[4];
    assign doff_out = master ? disp_off : ext_q[5];
    assign slp_out  = sleep;

endmodule

// File: rtl/lcd_frame_timer_chk.sv
// Checker for lcd_frame_timer, bound to every instance. Assumes master
// is steady outside reset and slave inputs are low during reset.
module lcd_frame_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic master,
    input logic cl_in,
    input logic ca_in,
    input logic fr_in,
    input logic cl_out,
    input logic ca_out,
    input logic f1_out,
    input logic f2_out,
    input logic fr_out,
    input logic doff_out,
    input logic slp_out
);

    // R8: line-rate outputs move only when the line clock falls.
    a_r8_change_on_cl_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (master && $past(master) && $past(rst_n) &&
         !$stable({f2_out, f1_out, fr_out, ca_out})) |-> $fell(cl_out));

    // R9: sleep always blanks the display in master mode.
    a_r9_sleep_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (master && slp_out) |-> doff_out);

    // R10: nothing on the line clock moves while asleep.
    a_r10_sleep_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (master && slp_out && $past(slp_out) && $past(rst_n)) |->
        ($stable(cl_out) && $stable(fr_out) && $stable({f2_out, f1_out})));

    // R11: slave outputs follow their inputs one clock later.
    a_r11_slave_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && $past(rst_n)) |->
        (cl_out == $past(cl_in) && ca_out == $past(ca_in) && fr_out == $past(fr_in)));

endmodule

bind lcd_frame_timer lcd_frame_timer_chk i_lcd_frame_timer_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .master  (master),
    .cl_in   (cl_in),
    .ca_in   (ca_in),
    .fr_in   (fr_in),
    .cl_out  (cl_out),
    .ca_out  (ca_out),
    .f1_out  (f1_out),
    .f2_out  (f2_out),
    .fr_out  (fr_out),
    .doff_out(doff_out),
    .slp_out (slp_out)
);

// File: tb/test_lcd_frame_timer.sv
// Directed bench for lcd_frame_timer: one task per scenario, with an
// independent line-by-line model checked at each observed CL fall.
module test_lcd_frame_timer;

    localparam int LINE_TICKS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_param = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       cl_in = 1'b0, ca_in = 1'b0, f1_in = 1'b0, f2_in = 1'b0;
    logic       fr_in = 1'b0, doff_in = 1'b0;
    logic       cl_out, ca_out, f1_out, f2_out, fr_out, doff_out, slp_out;

    int n_chk = 0;
    int n_fail = 0;

    int m_line, m_fs, m_step, m_iv, m_fr, m_frcnt;

    always #4ns clk = ~clk;

    lcd_frame_timer #(.LINE_TICKS(LINE_TICKS)) i_lcd_frame_timer (
        .clk(clk), .rst_n(rst_n), .master(master),
        .cmd_valid(cmd_valid), .cmd_param(cmd_param), .cmd_byte(cmd_byte),
        .cl_in(cl_in), .ca_in(ca_in), .f1_in(f1_in), .f2_in(f2_in),
        .fr_in(fr_in), .doff_in(doff_in),
        .cl_out(cl_out), .ca_out(ca_out), .f1_out(f1_out), .f2_out(f2_out),
        .fr_out(fr_out), .doff_out(doff_out), .slp_out(slp_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_pat(input int s);
        case (s)
            0: return 3; 1: return 2; 2: return 1; 3: return 0;
            4: return 0; 5: return 1; 6: return 2; default: return 3;
        endcase
    endfunction

    task automatic do_reset(input logic mst);
        rst_n = 1'b0; master = mst; cmd_valid = 1'b0;
        cl_in = 0; ca_in = 0; f1_in = 0; f2_in = 0; fr_in = 0; doff_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_line = 0; m_fs = 0; m_step = 0; m_iv = 0; m_fr = 0; m_frcnt = 0;
    endtask

    task automatic send(input logic prm, input logic [7:0] b);
        cmd_valid = 1'b1; cmd_param = prm; cmd_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_param = 1'b0;
    endtask

    // Follow n line boundaries and compare against the model.
    task automatic run_lines(input int n, input int lines, input int ic,
                             input int frn, input int ratio);
        int seen = 0, since = 0, moved = 0, ivlen;
        logic have_fall = 1'b0;
        logic prev_cl;
        logic [3:0] prev_o;
        ivlen = (ic == 0) ? 8 : (ic == 1) ? 4 : (ic == 2) ? 16 : 0;
        prev_cl = cl_out;
        prev_o  = {f2_out, f1_out, fr_out, ca_out};
        while (seen < n) begin
            @(negedge clk);
            since++;
            if (prev_cl && !cl_out) begin
                seen++;
                if (have_fall) chk("R2 line period", since, LINE_TICKS * ratio);
                have_fall = 1'b1;
                since = 0;
                if (m_line == lines - 1) begin
                    m_line = 0; m_fs = (m_fs + 1) % 8; m_step = m_fs; m_iv = 0;
                end else begin
                    m_line++;
                    if (ivlen != 0) begin
                        if (m_iv == ivlen - 1) begin m_iv = 0; m_step = (m_step + 1) % 8; end
                        else m_iv++;
                    end
                end
                if (m_frcnt == frn) begin m_frcnt = 0; m_fr = 1 - m_fr; end
                else m_frcnt++;
                chk("R4 R5 R6 pattern", {f2_out, f1_out}, exp_pat(m_step));
                chk("R7 polarity", fr_out, m_fr);
                chk("R3 field start", ca_out, (m_line == 0) ? 1 : 0);
            end else if ({f2_out, f1_out, fr_out, ca_out} != prev_o) begin
                moved++;
            end
            prev_cl = cl_out;
            prev_o  = {f2_out, f1_out, fr_out, ca_out};
        end
        chk("R8 changes away from CL fall", moved, 0);
    endtask

    task automatic t_reset_state();
        do_reset(1'b1);
        chk("R1 doff", doff_out, 1);
        chk("R1 slp", slp_out, 0);
        chk("R1 cl", cl_out, 0);
        chk("R1 ca", ca_out, 1);
        chk("R1 fr", fr_out, 0);
        chk("R1 pattern", {f2_out, f1_out}, 3);
    endtask

    task automatic t_defaults();
        do_reset(1'b1);
        run_lines(250, 240, 0, 10, 2);
    endtask

    task automatic t_config(input int dv, input int p, input int ic,
                            input int frn, input int ratio, input int n);
        do_reset(1'b1);
        send(0, 8'h95);
        send(0, 8'hBF); send(1, 8'(dv));
        send(0, 8'hA8); send(1, 8'(p));
        send(0, 8'hCC); send(1, 8'(ic));
        send(0, 8'hCA); send(1, 8'(frn));
        send(0, 8'h94);
        run_lines(n, 4 * (p + 1), ic, frn, ratio);
    endtask

    // R12: stray parameter bytes leave the 240-line default in place.
    task automatic t_orphan_param();
        do_reset(1'b1);
        send(0, 8'h95);
        send(1, 8'h01);
        send(0, 8'hA8); send(0, 8'hAF); send(1, 8'h01);
        send(0, 8'h94);
        chk("R12 doff after cancelled sequence", doff_out, 1);
        run_lines(30, 240, 0, 10, 2);
    endtask

    task automatic t_display();
        do_reset(1'b1);
        send(0, 8'hAF); chk("R9 on", doff_out, 0);
        send(0, 8'h95); chk("R9 sleep slp", slp_out, 1);
        chk("R9 sleep blanks", doff_out, 1);
        send(0, 8'hAF); chk("R9 on ignored in sleep", doff_out, 1);
        send(0, 8'h94); chk("R9 wake slp", slp_out, 0);
        chk("R9 wake stays blank", doff_out, 1);
        send(0, 8'hAF); chk("R9 on after wake", doff_out, 0);
        send(0, 8'hAE); chk("R9 off", doff_out, 1);
    endtask

    task automatic t_sleep_freeze();
        logic [4:0] snap;
        int moved = 0;
        do_reset(1'b1);
        run_lines(3, 240, 0, 10, 2);
        send(0, 8'h95);
        snap = {cl_out, ca_out, f2_out, f1_out, fr_out};
        repeat (40) begin
            @(negedge clk);
            if ({cl_out, ca_out, f2_out, f1_out, fr_out} != snap) moved++;
        end
        chk("R10 frozen in sleep", moved, 0);
    endtask

    task automatic t_slave();
        do_reset(1'b0);
        for (int i = 0; i < 8; i++) begin
            logic [2:0] v;
            v = 3'(i);
            cl_in = v[0]; ca_in = v[1]; f1_in = v[2]; f2_in = ~v[0];
            fr_in = v[1] ^ v[2]; doff_in = v[2];
            @(negedge clk);
            chk("R11 slave outputs",
                {cl_out, ca_out, f1_out, f2_out, fr_out, doff_out},
                {v[0], v[1], v[2], ~v[0], v[1] ^ v[2], v[2]});
        end
        send(0, 8'h95);
        chk("R11 slave sleep output", slp_out, 1);
        send(0, 8'h94);
        chk("R11 slave wake output", slp_out, 0);
    endtask

    initial begin
        t_reset_state();
        t_defaults();
        t_config(1, 1, 1, 3, 1, 30);
        t_config(2, 2, 3, 0, 4, 30);
        t_config(3, 0, 2, 5, 8, 20);
        t_orphan_param();
        t_display();
        t_sleep_freeze();
        t_slave();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule